// File: doc/BRIEF.md
# Torus Quadrant Route Computation Unit

This block computes the next output port for one hop of a packet that travels through a three-dimensional torus network-on-chip. Each router uses it once per hop. The router gives the block the coordinates of the node it sits at and the packet's destination coordinates. One clock later the block returns one of seven ports: Local, plus or minus X, plus or minus Y, or plus or minus Z. The plane size and the number of layers are parameters.

Only a few positions in the plane have a link between layers. The same positions carry that link in every layer, and a bit map parameter selects them. While the packet is on the wrong layer, the block steers it to the closest position that has a vertical link and then climbs or descends there. It makes no in-plane move toward the destination until the layers match. Once the packet is on the destination layer, the block corrects X fully and then Y. On each axis, a test on the quadrant positions of the two nodes and on the coordinate gap decides whether the packet goes straight or takes the torus wraparound edge.

Top module: `torus_route_unit`

## Requirements
- R1: The block registers the port with one cycle of latency. A request with `req_valid` high at a rising edge updates `out_port` at that edge. With `req_valid` low, `out_port` holds its value.
- R2: An asserted `rst_n` (low) sets `out_port` to Local at once. The port encoding is Local=0, +X=1, -X=2, +Y=3, -Y=4, +Z=5, -Z=6.
- R3: When the current and destination coordinates are equal on all three axes, the result is Local (0).
- R4: When the layers differ and the current position has a vertical link, the result is +Z (5) if the destination layer index is higher and -Z (6) if it is lower. Layers do not wrap.
- R5: When the layers differ and the current position has no vertical link, the block moves in the plane toward the vertical-link position at the smallest torus distance. Ties between positions go to the lowest linear index y*DIM_X+x. X is resolved before Y. When both directions on an axis are equally long, the block takes the positive one. It never emits a Z port here.
- R6: When the layers match, the block resolves X completely before it emits any Y port, and it never emits a Z port.
- R7: Each axis has a quadrant midpoint at floor(dim/2). The wraparound edge, which reverses the direct direction, is taken only when the two nodes lie in different plane quadrants and twice the coordinate gap exceeds the axis size. Otherwise the block moves directly, so an equal-length case such as 0 to 2 on a size-4 axis goes directly (+X). On a size-4 axis, 0 to 3 goes -X.
- R8: When the block is followed hop by hop, every source reaches every destination. On the same layer the hop count equals the torus distance between the nodes. Otherwise it equals the plane distance to the chosen link position, plus the layer gap, plus the plane distance from that position to the destination. The default 4x4x3 configuration has links at (0,0) and (2,2) (map 16'h0401).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Route request qualifier |
| cur_x | input | XW | Current node X coordinate |
| cur_y | input | YW | Current node Y coordinate |
| cur_z | input | ZW | Current node layer |
| dst_x | input | XW | Destination X coordinate |
| dst_y | input | YW | Destination Y coordinate |
| dst_z | input | ZW | Destination layer |
| out_port | output | 3 | Registered output port code |

## Verification
A port decision becomes visible on `out_port` one rising edge after the request is presented. The bench drives every request on a falling edge and reads the result on the following falling edge, which is exactly one register stage later. It also reads just after driving, to confirm that nothing has changed before the edge. Hold behaviour is checked one full cycle after inputs change with `req_valid` low. Reset is checked a moment after `rst_n` falls, because its effect is asynchronous. The hop-by-hop sweep feeds each returned port back as the next node, so every hop costs exactly one request cycle.

// File: rtl/torus_route_pkg.sv
package torus_route_pkg;

  typedef enum logic [2:0] {
    PORT_LOCAL = 3'd0,
    PORT_XP    = 3'd1,
    PORT_XN    = 3'd2,
    PORT_YP    = 3'd3,
    PORT_YN    = 3'd4,
    PORT_ZP    = 3'd5,
    PORT_ZN    = 3'd6
  } port_e;

  // shortest distance between two positions on a ring of size dim
  function automatic int unsigned ring_dist(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned dim);
    int unsigned d;
    d = (a > b) ? a - b : b - a;
    return (d > dim - d) ? dim - d : d;
  endfunction

endpackage

// File: rtl/torus_quad_axis.sv
// One axis of in-plane routing on the destination layer: direct or wraparound.
module torus_quad_axis #(
  parameter  int unsigned DIM = 4,
  localparam int unsigned W   = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] dst,
  input  logic         other_split,  // other axis lies across its midpoint
  output logic         split,        // this axis lies across its midpoint
  output logic         move,
  output logic         neg
);

  localparam int unsigned HALF = DIM / 2;

  logic [W-1:0] gap;
  logic         far;
  logic         wrap;

  always_comb begin
    split = (32'(cur) >= HALF) != (32'(dst) >= HALF);
    gap   = (cur > dst) ? cur - dst : dst - cur;
    far   = (2 * 32'(gap)) > DIM;
    wrap  = far && (split || other_split);
    move  = (cur != dst);
    neg   = wrap ? (dst > cur) : (dst < cur);
  end

endmodule

// File: rtl/torus_seek_axis.sv
// One axis of travel toward a vertical-link position: shortest way, tie positive.
module torus_seek_axis #(
  parameter  int unsigned DIM = 4,
  localparam int unsigned W   = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] tgt,
  output logic         move,
  output logic         neg
);

  int unsigned fwd;

  always_comb begin
    fwd  = (tgt >= cur) ? 32'(tgt) - 32'(cur) : DIM + 32'(tgt) - 32'(cur);
    move = (tgt != cur);
    neg  = move && ((2 * fwd) > DIM);
  end

endmodule

// File: rtl/torus_vlink_seek.sv
// Picks the closest plane position that owns a vertical link.
module torus_vlink_seek
  import torus_route_pkg::*;
#(
  parameter  int unsigned                  DIM_X     = 4,
  parameter  int unsigned                  DIM_Y     = 4,
  parameter  logic [DIM_X*DIM_Y-1:0]       VLINK_MAP = 'h0401,
  localparam int unsigned                  XW        = (DIM_X > 1) ? $clog2(DIM_X) : 1,
  localparam int unsigned                  YW        = (DIM_Y > 1) ? $clog2(DIM_Y) : 1
) (
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  output logic [XW-1:0] tgt_x,
  output logic [YW-1:0] tgt_y,
  output logic          at_link
);

  localparam int unsigned NODES = DIM_X * DIM_Y;
  localparam int unsigned IW    = (NODES > 1) ? $clog2(NODES) : 1;

  int unsigned       best;
  int unsigned       cand;
  logic [IW-1:0]     lin;

  always_comb begin
    best  = '1;
    cand  = '0;
    tgt_x = '0;
    tgt_y = '0;
    for (int n = 0; n < NODES; n++) begin
      cand = ring_dist(32'(cur_x), n % DIM_X, DIM_X) +
             ring_dist(32'(cur_y), n / DIM_X, DIM_Y);
      if (VLINK_MAP[IW'(n)] && (cand < best)) begin
        best  = cand;
        tgt_x = XW'(n % DIM_X);
        tgt_y = YW'(n / DIM_X);
      end
    end
    lin     = IW'(32'(cur_y) * DIM_X + 32'(cur_x));
    at_link = VLINK_MAP[lin];
  end

endmodule

// File: rtl/torus_route_unit.sv
module torus_route_unit
  import torus_route_pkg::*;
#(
  parameter  int unsigned            DIM_X     = 4,
  parameter  int unsigned            DIM_Y     = 4,
  parameter  int unsigned            DIM_Z     = 3,
  parameter  logic [DIM_X*DIM_Y-1:0] VLINK_MAP = 'h0401,
  localparam int unsigned            XW        = (DIM_X > 1) ? $clog2(DIM_X) : 1,
  localparam int unsigned            YW        = (DIM_Y > 1) ? $clog2(DIM_Y) : 1,
  localparam int unsigned            ZW        = (DIM_Z > 1) ? $clog2(DIM_Z) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [XW-1:0] cur_x,
  input  logic [YW-1:0] cur_y,
  input  logic [ZW-1:0] cur_z,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  input  logic [ZW-1:0] dst_z,
  output logic [2:0]    out_port
);

  logic [XW-1:0] tgt_x;
  logic [YW-1:0] tgt_y;
  logic          at_link;
  logic          sx_move, sx_neg, sy_move, sy_neg;
  logic          qx_move, qx_neg, qx_split;
  logic          qy_move, qy_neg, qy_split;
  port_e         port_d;
  port_e         port_q;

  torus_vlink_seek #(
    .DIM_X(DIM_X), .DIM_Y(DIM_Y), .VLINK_MAP(VLINK_MAP)
  ) u_seek (
    .cur_x(cur_x), .cur_y(cur_y),
    .tgt_x(tgt_x), .tgt_y(tgt_y), .at_link(at_link)
  );

  torus_seek_axis #(.DIM(DIM_X)) u_seek_x (
    .cur(cur_x), .tgt(tgt_x), .move(sx_move), .neg(sx_neg)
  );

  torus_seek_axis #(.DIM(DIM_Y)) u_seek_y (
    .cur(cur_y), .tgt(tgt_y), .move(sy_move), .neg(sy_neg)
  );

  torus_quad_axis #(.DIM(DIM_X)) u_quad_x (
    .cur(cur_x), .dst(dst_x), .other_split(qy_split),
    .split(qx_split), .move(qx_move), .neg(qx_neg)
  );

  torus_quad_axis #(.DIM(DIM_Y)) u_quad_y (
    .cur(cur_y), .dst(dst_y), .other_split(qx_split),
    .split(qy_split), .move(qy_move), .neg(qy_neg)
  );

  // next-state: layer first, then X, then Y
  always_comb begin
    port_d = PORT_LOCAL;
    if (cur_z != dst_z) begin
      if (at_link)      port_d = (dst_z > cur_z) ? PORT_ZP : PORT_ZN;
      else if (sx_move) port_d = sx_neg ? PORT_XN : PORT_XP;
      else if (sy_move) port_d = sy_neg ? PORT_YN : PORT_YP;
    end else begin
      if (qx_move)      port_d = qx_neg ? PORT_XN : PORT_XP;
      else if (qy_move) port_d = qy_neg ? PORT_YN : PORT_YP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         port_q <= PORT_LOCAL;
    else if (req_valid) port_q <= port_d;
  end

  assign out_port = port_q;

endmodule

// File: rtl/torus_route_unit_chk.sv
module torus_route_unit_chk #(
  parameter  int unsigned            DIM_X     = 4,
  parameter  int unsigned            DIM_Y     = 4,
  parameter  int unsigned            DIM_Z     = 3,
  parameter  logic [DIM_X*DIM_Y-1:0] VLINK_MAP = 'h0401,
  localparam int unsigned            XW        = (DIM_X > 1) ? $clog2(DIM_X) : 1,
  localparam int unsigned            YW        = (DIM_Y > 1) ? $clog2(DIM_Y) : 1,
  localparam int unsigned            ZW        = (DIM_Z > 1) ? $clog2(DIM_Z) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [XW-1:0] cur_x,
  input logic [YW-1:0] cur_y,
  input logic [ZW-1:0] cur_z,
  input logic [XW-1:0] dst_x,
  input logic [YW-1:0] dst_y,
  input logic [ZW-1:0] dst_z,
  input logic [2:0]    out_port
);

  localparam int unsigned NODES = DIM_X * DIM_Y;
  localparam int unsigned IW    = (NODES > 1) ? $clog2(NODES) : 1;

  logic [IW-1:0] pos;
  logic          has_link;
  logic          same_node;

  assign pos       = IW'(32'(cur_y) * DIM_X + 32'(cur_x));
  assign has_link  = VLINK_MAP[pos];
  assign same_node = (cur_x == dst_x) && (cur_y == dst_y) && (cur_z == dst_z);

  always @(posedge clk) begin
    if (!rst_n) a_r2_reset_local: assert (out_port == 3'd0);
  end

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(out_port));

  a_r3_arrived_local: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && same_node |=> out_port == 3'd0);

  a_r4_climb: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && has_link && (dst_z > cur_z) |=> out_port == 3'd5);

  a_r4_descend: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && has_link && (dst_z < cur_z) |=> out_port == 3'd6);

  a_r5_plane_seek: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !has_link && (dst_z != cur_z) |=> out_port inside {3'd1, 3'd2, 3'd3, 3'd4});

  a_r6_x_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (cur_z == dst_z) && (cur_x != dst_x) |=> out_port inside {3'd1, 3'd2});

  a_r6_y_last: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (cur_z == dst_z) && (cur_x == dst_x) && (cur_y != dst_y)
    |=> out_port inside {3'd3, 3'd4});

endmodule

bind torus_route_unit torus_route_unit_chk #(
  .DIM_X(DIM_X), .DIM_Y(DIM_Y), .DIM_Z(DIM_Z), .VLINK_MAP(VLINK_MAP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
  .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z),
  .out_port(out_port)
);

// File: tb/torus_route_unit_tb.sv
module torus_route_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DX = 4;
  localparam int DY = 4;
  localparam int DZ = 3;
  localparam logic [15:0] VMAP = 16'h0401;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] cur_x, cur_y, cur_z, dst_x, dst_y, dst_z;
  logic [2:0] out_port;

  int n_checks = 0;
  int n_fail   = 0;

  torus_route_unit #(
    .DIM_X(DX), .DIM_Y(DY), .DIM_Z(DZ), .VLINK_MAP(VMAP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .cur_x(cur_x), .cur_y(cur_y), .cur_z(cur_z),
    .dst_x(dst_x), .dst_y(dst_y), .dst_z(dst_z),
    .out_port(out_port)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tdist(input int a, input int b, input int dim);
    int d;
    d = (a > b) ? a - b : b - a;
    return (d > dim - d) ? dim - d : d;
  endfunction

  function automatic int pdist(input int ax, input int ay, input int bx, input int by);
    return tdist(ax, bx, DX) + tdist(ay, by, DY);
  endfunction

  function automatic bit linked(input int x, input int y);
    return VMAP[y * DX + x];
  endfunction

  function automatic int ref_hops(input int sx, input int sy, input int sz,
                                  input int ex, input int ey, input int ez);
    int best, bx, by, dz;
    if (sz == ez) return pdist(sx, sy, ex, ey);
    best = 1000; bx = 0; by = 0;
    for (int n = 0; n < DX * DY; n++) begin
      if (VMAP[n] && pdist(sx, sy, n % DX, n / DX) < best) begin
        best = pdist(sx, sy, n % DX, n / DX);
        bx = n % DX; by = n / DX;
      end
    end
    dz = (ez > sz) ? ez - sz : sz - ez;
    return best + dz + pdist(bx, by, ex, ey);
  endfunction

  // present a request on a falling edge, read the result one edge later
  task automatic request(input int cx, input int cy, input int cz,
                         input int ex, input int ey, input int ez, output int p);
    @(negedge clk);
    cur_x = 2'(cx); cur_y = 2'(cy); cur_z = 2'(cz);
    dst_x = 2'(ex); dst_y = 2'(ey); dst_z = 2'(ez);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    p = int'(out_port);
  endtask

  task automatic expect_port(input string req, input int cx, input int cy, input int cz,
                             input int ex, input int ey, input int ez, input int exp);
    int p;
    request(cx, cy, cz, ex, ey, ez, p);
    check(p == exp, req, p, exp);
  endtask

  task automatic walk(input int sx, input int sy, input int sz,
                      input int ex, input int ey, input int ez);
    int x, y, z, hops, p, exp;
    bit legal;
    x = sx; y = sy; z = sz; hops = 0; legal = 1'b1;
    while (!(x == ex && y == ey && z == ez) && hops < 32 && legal) begin
      request(x, y, z, ex, ey, ez, p);
      hops++;
      case (p)
        1: x = (x + 1) % DX;
        2: x = (x + DX - 1) % DX;
        3: y = (y + 1) % DY;
        4: y = (y + DY - 1) % DY;
        5: if (!linked(x, y) || z == DZ - 1) legal = 1'b0; else z++;
        6: if (!linked(x, y) || z == 0) legal = 1'b0; else z--;
        default: legal = 1'b0;
      endcase
    end
    check(legal, "R4 R5 vertical hop only at a link node", int'(legal), 1);
    check(x == ex && y == ey && z == ez, "R8 destination reached",
          x * 100 + y * 10 + z, ex * 100 + ey * 10 + ez);
    exp = ref_hops(sx, sy, sz, ex, ey, ez);
    check(hops == exp, "R8 hop count", hops, exp);
    request(ex, ey, ez, ex, ey, ez, p);
    check(p == 0, "R3 local at destination", p, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int p;
    rst_n = 1'b0; req_valid = 1'b0;
    cur_x = '0; cur_y = '0; cur_z = '0; dst_x = '0; dst_y = '0; dst_z = '0;
    repeat (3) @(negedge clk);
    check(out_port == 3'd0, "R2 reset state", int'(out_port), 0);
    rst_n = 1'b1;

    // R1 latency: nothing moves before the edge, result after it
    @(negedge clk);
    cur_x = 2'd0; cur_y = 2'd1; cur_z = 2'd0;
    dst_x = 2'd3; dst_y = 2'd1; dst_z = 2'd0;
    req_valid = 1'b1;
    #1;
    check(out_port == 3'd0, "R1 no change before edge", int'(out_port), 0);
    @(negedge clk);
    req_valid = 1'b0;
    check(out_port == 3'd2, "R1 R7 wraparound 0->3 gives -X", int'(out_port), 2);
    cur_x = 2'd1; dst_x = 2'd2; dst_z = 2'd2;
    @(negedge clk);
    check(out_port == 3'd2, "R1 hold without request", int'(out_port), 2);

    expect_port("R7 equal length goes direct +X", 0, 1, 0, 2, 1, 0, 1);
    expect_port("R7 equal length goes direct -X", 2, 1, 0, 0, 1, 0, 2);
    expect_port("R7 R6 wraparound on Y gives -Y", 1, 0, 1, 1, 3, 1, 4);
    expect_port("R6 X resolved before Y", 1, 1, 1, 3, 3, 1, 1);
    expect_port("R4 climb at link node", 2, 2, 0, 0, 0, 2, 5);
    expect_port("R4 descend at link node", 0, 0, 2, 1, 1, 0, 6);
    expect_port("R5 tie to lowest index link, -X", 1, 1, 0, 1, 1, 2, 2);
    expect_port("R5 equal length seek goes +X", 2, 0, 0, 2, 0, 2, 1);
    expect_port("R5 seek on Y gives +Y", 0, 3, 1, 0, 3, 0, 3);
    expect_port("R3 same node gives Local", 3, 2, 1, 3, 2, 1, 0);

    // R2 asynchronous reset from a non-Local value
    request(0, 1, 0, 3, 1, 0, p);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(out_port == 3'd0, "R2 reset clears port", int'(out_port), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8 full sweep of all source/destination pairs
    for (int s = 0; s < DX * DY * DZ; s++) begin
      for (int d = 0; d < DX * DY * DZ; d++) begin
        walk(s % DX, (s / DX) % DY, s / (DX * DY),
             d % DX, (d / DX) % DY, d / (DX * DY));
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule